// File: doc/BRIEF.md
# Supply Supervisor with Protection Latch

This block sequences a switching controller through power-up, soft-start, normal running and shutdown. It works only from comparator flags on the supply rail and from fault flags. Three rail flags are used: the supply has reached the start level, the supply is below the stop level, and the supply is at or below the bias level. From these it opens and closes the switching enable. It raises a request for the high-voltage startup current (bias assist) whenever the rail sags to the bias level, so that the rail never reaches the stop level while the block must stay alive.

Once switching is enabled, a stepped soft-start raises the allowed peak current in equal steps. An overload timer watches the maximum-feedback flag, and a protection latch handles overvoltage, over-temperature and overload. A latched fault is held, with bias assist keeping the rail up, until input power goes away and the rail drops below the stop level. In auto-restart mode an overload is not latched. Bias assist is withheld instead, so the rail decays through undervoltage lockout and the block starts again when the rail recovers, which gives intermittent operation.

All asynchronous flags pass through two-flop synchronizers. The soft-start step length and the overload delay are parameters counted in clock cycles.

Top module: `supply_supervisor`

## Requirements
- R1: After reset, `sw_en_o`, `bias_req_o`, `ss_step_o` and `fault_cause_o` are all 0. Switching is enabled only when the start flag is seen while the stop flag is low. A flag change reaches the outputs on the third rising clock edge after it, not on the second.
- R2: While switching, the start flag falling has no effect (hysteresis). The stop flag rising disables switching and returns `ss_step_o` to 0.
- R3: `bias_req_o` follows the bias flag in every state except the auto-restart overload state. This includes the off state, soft-start, running and the fault latch.
- R4: After enable, `ss_step_o` counts 0, 1, 2, 3, each value held for STEP_CYC cycles. It then stays at 3 while running and never decreases while switching.
- R5: A high overvoltage flag stops switching and latches cause 2.
- R6: A high thermal flag stops switching and latches cause 3. When overvoltage and thermal rise together, the cause is 2.
- R7: `fault_cause_o` holds the first fault seen. Later fault flags do not change it while the latch is held.
- R8: While latched, switching stays off even when the fault flag clears and the start flag is high.
- R9: Only the stop flag releases a fault. It clears `fault_cause_o` to 0, and a later start flag enables switching again.
- R10: An overload fires only after the maximum-feedback flag has been high during switching for OLP_CYC consecutive synchronized cycles. Switching then stops on the (OLP_CYC+2)-th edge after the flag rises, and a shorter high pulse restarts the count.
- R11: With `auto_restart_i` low, an overload latches cause 1 and behaves like any other latched fault.
- R12: With `auto_restart_i` high, an overload records cause 1, stops switching and forces `bias_req_o` to 0 even when the bias flag is high. It stays off until the stop flag is seen, and then restarts normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vcc_start_i | input | 1 | Supply at or above the start level (async) |
| vcc_stop_i | input | 1 | Supply below the stop level (async) |
| vcc_bias_i | input | 1 | Supply at or below the bias level (async) |
| ovp_i | input | 1 | Overvoltage flag (async) |
| otp_i | input | 1 | Over-temperature flag (async) |
| fb_max_i | input | 1 | Feedback at its maximum level (async) |
| auto_restart_i | input | 1 | 1 = overload retries through lockout, 0 = overload latches |
| sw_en_o | output | 1 | Switching enable |
| bias_req_o | output | 1 | Startup-current (bias assist) request |
| ss_step_o | output | STEP_W | Soft-start step index |
| fault_cause_o | output | 2 | 0 none, 1 overload, 2 overvoltage, 3 thermal |

## Verification
A wrong sequencer state shows on `sw_en_o` and `fault_cause_o` three edges after the flag that should have moved it. That is where the bench samples every transition. A soft-start counter that is off by one moves the `ss_step_o` edges by whole cycles, so the step value is checked at both ends of each step. An overload timer that is off by one makes `sw_en_o` fall one edge early or late against the OLP_CYC+2 edge prediction. A bias-assist error in auto-restart shows as `bias_req_o` high while the bias flag is high.

// File: rtl/ssv_pkg.sv
package ssv_pkg;

    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,
        ST_SOFT  = 3'd1,
        ST_RUN   = 3'd2,
        ST_LATCH = 3'd3,
        ST_RETRY = 3'd4
    } ssv_state_e;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'd0,
        CAUSE_OLP  = 2'd1,
        CAUSE_OVP  = 2'd2,
        CAUSE_OTP  = 2'd3
    } ssv_cause_e;

    typedef struct packed {
        ssv_state_e state;
        ssv_cause_e cause;
        logic       bias_req;
    } ssv_regs_t;

endpackage

// File: rtl/ssv_sync.sv
module ssv_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta_q;
        logic hold_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                hold_q <= 1'b0;
            end else begin
                meta_q <= async_i[i];
                hold_q <= meta_q;
            end
        end
        assign sync_o[i] = hold_q;
    end

endmodule

// File: rtl/ssv_ramp.sv
module ssv_ramp #(
    parameter int STEP_CYC = 8,
    parameter int SS_STEPS = 4,
    localparam int CNT_W  = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1,
    localparam int STEP_W = (SS_STEPS > 1) ? $clog2(SS_STEPS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_i,
    output logic [STEP_W-1:0] step_o,
    output logic              done_o
);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [STEP_W-1:0] step;
    } ramp_t;

    ramp_t r_d, r_q;
    logic  tick;

    always_comb begin
        tick   = adv_i && (r_q.cnt == CNT_W'(STEP_CYC - 1));
        done_o = tick && (r_q.step == STEP_W'(SS_STEPS - 1));
        r_d    = r_q;
        if (!adv_i) begin
            r_d.cnt  = '0;
            r_d.step = '0;
        end else if (tick) begin
            r_d.cnt = '0;
            if (!done_o) begin
                r_d.step = r_q.step + 1'b1;
            end
        end else begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign step_o = r_q.step;

endmodule

// File: rtl/ssv_olp_timer.sv
module ssv_olp_timer #(
    parameter int OLP_CYC = 20,
    localparam int CNT_W = (OLP_CYC > 1) ? $clog2(OLP_CYC) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic fire_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        fire_o = en_i && (cnt_q == CNT_W'(OLP_CYC - 1));
        if (!en_i) begin
            cnt_d = '0;
        end else if (fire_o) begin
            cnt_d = cnt_q;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/supply_supervisor.sv
module supply_supervisor
    import ssv_pkg::*;
#(
    parameter int STEP_CYC = 151250,
    parameter int OLP_CYC  = 90000000,
    parameter int SS_STEPS = 4,
    localparam int STEP_W  = (SS_STEPS > 1) ? $clog2(SS_STEPS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vcc_start_i,
    input  logic              vcc_stop_i,
    input  logic              vcc_bias_i,
    input  logic              ovp_i,
    input  logic              otp_i,
    input  logic              fb_max_i,
    input  logic              auto_restart_i,
    output logic              sw_en_o,
    output logic              bias_req_o,
    output logic [STEP_W-1:0] ss_step_o,
    output logic [1:0]        fault_cause_o
);

    localparam int NFLAG = 7;

    logic [NFLAG-1:0] flags_a, flags_s;
    logic start_s, stop_s, bias_s, ovp_s, otp_s, fbmax_s, retry_s;

    assign flags_a = {auto_restart_i, fb_max_i, otp_i, ovp_i,
                      vcc_bias_i, vcc_stop_i, vcc_start_i};

    ssv_sync #(.W(NFLAG)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (flags_a),
        .sync_o  (flags_s)
    );

    assign start_s = flags_s[0];
    assign stop_s  = flags_s[1];
    assign bias_s  = flags_s[2];
    assign ovp_s   = flags_s[3];
    assign otp_s   = flags_s[4];
    assign fbmax_s = flags_s[5];
    assign retry_s = flags_s[6];

    ssv_regs_t  st_d, st_q;
    ssv_state_e cur_state;
    logic       switching;
    logic       in_soft;
    logic       ramp_done;
    logic       olp_fire;
    logic [STEP_W-1:0] ramp_step;

    assign cur_state = st_q.state;
    assign switching = (cur_state == ST_SOFT) || (cur_state == ST_RUN);
    assign in_soft   = (cur_state == ST_SOFT);

    ssv_ramp #(.STEP_CYC(STEP_CYC), .SS_STEPS(SS_STEPS)) u_ramp (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv_i  (in_soft),
        .step_o (ramp_step),
        .done_o (ramp_done)
    );

    ssv_olp_timer #(.OLP_CYC(OLP_CYC)) u_olp (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (switching && fbmax_s),
        .fire_o (olp_fire)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q.state)
            ST_OFF: begin
                if (start_s && !stop_s) begin
                    st_d.state = ST_SOFT;
                end
            end
            ST_SOFT, ST_RUN: begin
                if (stop_s) begin
                    st_d.state = ST_OFF;
                end else if (ovp_s) begin
                    st_d.state = ST_LATCH;
                    st_d.cause = CAUSE_OVP;
                end else if (otp_s) begin
                    st_d.state = ST_LATCH;
                    st_d.cause = CAUSE_OTP;
                end else if (olp_fire) begin
                    st_d.state = retry_s ? ST_RETRY : ST_LATCH;
                    st_d.cause = CAUSE_OLP;
                end else if (in_soft && ramp_done) begin
                    st_d.state = ST_RUN;
                end
            end
            ST_LATCH, ST_RETRY: begin
                if (stop_s) begin
                    st_d.state = ST_OFF;
                    st_d.cause = CAUSE_NONE;
                end
            end
            default: begin
                st_d.state = ST_OFF;
                st_d.cause = CAUSE_NONE;
            end
        endcase
        st_d.bias_req = bias_s && (st_d.state != ST_RETRY);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{state: ST_OFF, cause: CAUSE_NONE, bias_req: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (cur_state)
            ST_SOFT: ss_step_o = ramp_step;
            ST_RUN:  ss_step_o = STEP_W'(SS_STEPS - 1);
            default: ss_step_o = '0;
        endcase
    end

    assign sw_en_o       = switching;
    assign bias_req_o    = st_q.bias_req;
    assign fault_cause_o = st_q.cause;

endmodule

// File: rtl/ssv_checker.sv
module ssv_checker
    import ssv_pkg::*;
#(
    parameter int STEP_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sw_en_o,
    input logic              bias_req_o,
    input logic [STEP_W-1:0] ss_step_o,
    input logic [1:0]        fault_cause_o,
    input logic              start_s,
    input logic              stop_s,
    input ssv_state_e        cur_state
);

    p_start_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_en_o) |-> $past(start_s));

    p_stop_kills_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stop_s |=> !sw_en_o);

    p_step_monotonic_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_en_o && $past(sw_en_o)) |-> (ss_step_o >= $past(ss_step_o)));

    p_fault_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_cause_o != 2'd0) |-> !sw_en_o);

    p_cause_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((fault_cause_o != 2'd0) && !stop_s) |=> $stable(fault_cause_o));

    p_retry_no_bias_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == ST_RETRY) |-> !bias_req_o);

endmodule

bind supply_supervisor ssv_checker #(.STEP_W(STEP_W)) u_ssv_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .sw_en_o       (sw_en_o),
    .bias_req_o    (bias_req_o),
    .ss_step_o     (ss_step_o),
    .fault_cause_o (fault_cause_o),
    .start_s       (start_s),
    .stop_s        (stop_s),
    .cur_state     (cur_state)
);

// File: tb/supply_supervisor_bench.sv
`timescale 1ns/1ps
module supply_supervisor_bench;

    localparam int STEP = 8;
    localparam int OLP  = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, stop = 1'b1, bias = 1'b1;
    logic ovp = 1'b0, otp = 1'b0, fbmax = 1'b0, ar = 1'b0;
    logic       sw_en, bias_req;
    logic [1:0] step, cause;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    supply_supervisor #(.STEP_CYC(STEP), .OLP_CYC(OLP), .SS_STEPS(4)) u_supply_supervisor (
        .clk(clk), .rst_n(rst_n),
        .vcc_start_i(start), .vcc_stop_i(stop), .vcc_bias_i(bias),
        .ovp_i(ovp), .otp_i(otp), .fb_max_i(fbmax), .auto_restart_i(ar),
        .sw_en_o(sw_en), .bias_req_o(bias_req),
        .ss_step_o(step), .fault_cause_o(cause)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic power_up();
        stop = 1'b0; bias = 1'b0; start = 1'b1;
        tick(3);
    endtask

    task automatic power_down();
        stop = 1'b1; start = 1'b0; bias = 1'b1;
        tick(3);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset sw_en", sw_en, 0);
        chk("R1 reset bias_req", bias_req, 0);
        chk("R1 reset step", step, 0);
        chk("R1 reset cause", cause, 0);
        rst_n = 1'b1;
        tick(3);
        chk("R3 bias in off", bias_req, 1);
        chk("R1 no start no enable", sw_en, 0);

        stop = 1'b0; bias = 1'b0;
        tick(3);
        chk("R3 bias released", bias_req, 0);
        chk("R1 above stop only", sw_en, 0);

        start = 1'b1;
        tick(2);
        chk("R1 latency two edges", sw_en, 0);
        tick(1);
        chk("R1 enabled third edge", sw_en, 1);
        for (int k = 0; k < 4; k++) begin
            chk("R4 step start", step, k);
            tick(STEP - 1);
            chk("R4 step end", step, k);
            tick(1);
        end
        chk("R4 step held after ramp", step, 3);
        tick(10);
        chk("R4 step stays full", step, 3);

        start = 1'b0;
        tick(3);
        chk("R2 hysteresis", sw_en, 1);
        bias = 1'b1;
        tick(3);
        chk("R3 bias while running", bias_req, 1);
        chk("R2 running with bias", sw_en, 1);
        bias = 1'b0;
        stop = 1'b1;
        tick(3);
        chk("R2 stop disables", sw_en, 0);
        chk("R2 step cleared", step, 0);

        power_up();
        ovp = 1'b1; otp = 1'b1;
        tick(3);
        chk("R6 priority cause", cause, 2);
        chk("R6 stopped", sw_en, 0);
        ovp = 1'b0; otp = 1'b0;
        power_down();
        chk("R9 release", cause, 0);

        power_up();
        tick(4 * STEP + 2);
        fbmax = 1'b1; tick(OLP / 2);
        fbmax = 1'b0; tick(3);
        fbmax = 1'b1; tick(OLP / 2);
        fbmax = 1'b0; tick(4);
        chk("R10 short pulses no trip", sw_en, 1);
        chk("R10 short pulses cause", cause, 0);
        power_down();

        for (int fk = 0; fk < 4; fk++) begin
            for (int ph = 0; ph < 2; ph++) begin
                ar = (fk == 3);
                power_up();
                chk("R9 start after release", sw_en, 1);
                if (ph == 1) tick(4 * STEP + 2);
                if (fk == 0) ovp = 1'b1;
                else if (fk == 1) otp = 1'b1;
                else fbmax = 1'b1;
                if (fk < 2) begin
                    tick(2);
                    chk("R5 fault latency", sw_en, 1);
                    tick(1);
                    chk("R5 fault stops switching", sw_en, 0);
                    chk("R6 cause code", cause, (fk == 0) ? 2 : 3);
                end else begin
                    tick(OLP + 1);
                    chk("R10 before delay", sw_en, 1);
                    tick(1);
                    chk("R10 overload stops", sw_en, 0);
                    chk("R11 overload cause", cause, 1);
                end
                ovp = 1'b0; otp = 1'b0; fbmax = 1'b0; bias = 1'b1;
                tick(4);
                if (fk == 3) chk("R12 no bias in retry", bias_req, 0);
                else chk("R3 bias held in latch", bias_req, 1);
                chk("R8 stays off", sw_en, 0);
                if (fk == 0) otp = 1'b1;
                tick(4);
                chk("R7 first cause kept", cause, (fk == 0) ? 2 : ((fk == 1) ? 3 : 1));
                otp = 1'b0;
                stop = 1'b1; start = 1'b0;
                tick(3);
                chk("R9 stop clears cause", cause, 0);
                chk("R12 bias after lockout", bias_req, 1);
                power_up();
                chk("R9 restart", sw_en, 1);
                power_down();
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule